// File: doc/BRIEF.md
# Key-Guarded Setup Register

This block holds a small set of control bits for a flash controller and its neighbours: a program-image swap enable, an auto-increment enable for the flash address pointer, a keyhole DMA enable and a debug-port enable. Software cannot change these bits with a single stray store. It must first write a fixed 32-bit unlock word into a separate key register. The setup register then accepts writes until software writes anything other than that word to the key register, which locks it again.

A read-only mode flag, fixed at build time and set by default, decides whether the swap bit can have any effect. The swap bit and the debug bit take their reset values from two strap inputs, which are sampled while reset is held. The increment and DMA bits reset to zero. Both registers sit on a plain register bus with a write strobe, an address, 32-bit write data with per-byte strobes, and read data that follows the address combinationally. The bus has no valid/ready handshake: every write completes in the cycle it is presented.

Top module: `cfg_lockreg`

## Requirements
- R1: The block uses a synchronous active-low reset. While `rst_n` is low it is locked, `inc_en` and `dma_en` are 0, the swap bit takes the value of `strap_swap` and the debug bit takes the value of `strap_dbg`. These values hold from the first cycle after reset is released.
- R2: A write to the key register (byte offset 0x0) with all four byte strobes set and data 0xF123F456 unlocks the block from the next cycle.
- R3: A write to the setup register (byte offset 0x4) while the block is locked leaves all stored bits unchanged.
- R4: Once unlocked, the block stays unlocked across any number of setup-register writes and other accesses until the key register is written again.
- R5: Any key-register write that is not the unlock word with all strobes set locks the block from the next cycle. This includes the unlock word written with a partial strobe.
- R6: Reading offset 0x4 returns bit 0 debug, bit 1 DMA, bit 2 increment, bit 3 swap and bit 4 the mode flag, with bits 31:5 zero. Reading the key register returns zero.
- R7: `effective_swap` is high only when the stored swap bit and the mode flag are both 1.
- R8: An unlocked setup write changes the bits only when byte strobe 0 is set. Write data bits 31:4 have no effect, so the mode flag cannot be written.
- R9: `inc_en`, `dma_en` and `dbg_en` follow the stored bits from the cycle after an accepted write.
- R10: A write to any offset other than 0x0 or 0x4 changes nothing, and reading such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_swap | input | 1 | Reset value of the swap bit |
| strap_dbg | input | 1 | Reset value of the debug bit |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| effective_swap | output | 1 | Swap bit gated by the mode flag |
| inc_en | output | 1 | Auto-increment enable |
| dma_en | output | 1 | Keyhole DMA enable |
| dbg_en | output | 1 | Debug access enable |

## Verification
The hardest state to reach is an unlocked block that is then closed by a write that nearly matches the key. That write carries the exact unlock word but drops one byte strobe. The stimulus first unlocks the block and makes several accepted setup writes to show that the unlock persists. It then issues the partial-strobe key write and tries a setup write, which must be ignored. Two resets with opposite strap values cover both reset values of the strapped bits.

// File: rtl/cfg_lockreg_pkg.sv
package cfg_lockreg_pkg;
  // bit positions inside the setup word
  localparam int unsigned POS_DBG  = 0;
  localparam int unsigned POS_DMA  = 1;
  localparam int unsigned POS_INC  = 2;
  localparam int unsigned POS_SWAP = 3;
  localparam int unsigned POS_MODE = 4;
  localparam int unsigned CTRL_W   = 4;

  typedef struct packed {
    logic swap;
    logic inc;
    logic dma;
    logic dbg;
  } setup_t;

  function automatic setup_t unpack_ctrl(input logic [CTRL_W-1:0] v);
    setup_t s;
    s.swap = v[POS_SWAP];
    s.inc  = v[POS_INC];
    s.dma  = v[POS_DMA];
    s.dbg  = v[POS_DBG];
    return s;
  endfunction
endpackage

// File: rtl/cfg_key_guard.sv
module cfg_key_guard #(
  parameter int unsigned          DATA_W = 32,
  parameter logic [DATA_W-1:0]    KEY    = 32'hF123F456,
  localparam int unsigned         BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_key,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic              unlocked
);
  logic key_match;

  // a full-width write of the exact key opens; any other key write closes
  assign key_match = (&be) && (wdata == KEY);

  always_ff @(posedge clk) begin
    if (!rst_n)
      unlocked <= 1'b0;
    else if (wr_key)
      unlocked <= key_match;
  end
endmodule

// File: rtl/cfg_setup_bits.sv
module cfg_setup_bits
  import cfg_lockreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_swap,
  input  logic              strap_dbg,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wbits,
  output setup_t            q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q.swap <= strap_swap;
      q.inc  <= 1'b0;
      q.dma  <= 1'b0;
      q.dbg  <= strap_dbg;
    end else if (wr_en) begin
      q <= unpack_ctrl(wbits);
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_lockreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              sel_setup,
  input  logic              mode_flag,
  input  setup_t            q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel_setup) begin
      rdata[POS_SWAP] = q.swap;
      rdata[POS_INC]  = q.inc;
      rdata[POS_DMA]  = q.dma;
      rdata[POS_DBG]  = q.dbg;
      rdata[POS_MODE] = mode_flag;
    end
  end
endmodule

// File: rtl/cfg_lockreg.sv
module cfg_lockreg
  import cfg_lockreg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY       = 32'hF123F456,
  parameter logic [ADDR_W-1:0] KEY_OFS   = 4'h0,
  parameter logic [ADDR_W-1:0] SETUP_OFS = 4'h4,
  parameter bit                MODE_FLAG = 1'b1,
  localparam int unsigned      BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_swap,
  input  logic              strap_dbg,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              effective_swap,
  output logic              inc_en,
  output logic              dma_en,
  output logic              dbg_en
);
  logic   hit_key, hit_setup, wr_key, wr_setup;
  logic   unlocked;
  logic   mode_flag;
  setup_t cur;

  assign hit_key   = (bus_addr == KEY_OFS);
  assign hit_setup = (bus_addr == SETUP_OFS);
  assign wr_key    = bus_we && hit_key;
  assign wr_setup  = bus_we && hit_setup && unlocked && bus_be[0];
  assign mode_flag = MODE_FLAG;

  cfg_key_guard #(.DATA_W(DATA_W), .KEY(KEY)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_key   (wr_key),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .unlocked (unlocked)
  );

  cfg_setup_bits u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_swap (strap_swap),
    .strap_dbg  (strap_dbg),
    .wr_en      (wr_setup),
    .wbits      (bus_wdata[CTRL_W-1:0]),
    .q          (cur)
  );

  cfg_read_mux #(.DATA_W(DATA_W)) u_rd (
    .sel_setup (hit_setup),
    .mode_flag (mode_flag),
    .q         (cur),
    .rdata     (bus_rdata)
  );

  generate
    if (MODE_FLAG) begin : g_swap_live
      assign effective_swap = cur.swap;
    end else begin : g_swap_dead
      assign effective_swap = 1'b0;
    end
  endgenerate

  assign inc_en = cur.inc;
  assign dma_en = cur.dma;
  assign dbg_en = cur.dbg;
endmodule

// File: rtl/cfg_lockreg_chk.sv
module cfg_lockreg_chk #(
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] KEY       = 32'hF123F456,
  parameter logic [ADDR_W-1:0] KEY_OFS   = 4'h0,
  parameter logic [ADDR_W-1:0] SETUP_OFS = 4'h4,
  parameter bit                MODE_FLAG = 1'b1,
  localparam int unsigned      BE_W      = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [BE_W-1:0]   bus_be,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              effective_swap,
  input logic              unlocked,
  input logic [3:0]        cur_bits
);
  // R2
  unlock_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KEY_OFS && (&bus_be) && bus_wdata == KEY) |=> unlocked);

  // R5
  relock_on_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == KEY_OFS && !((&bus_be) && bus_wdata == KEY)) |=> !unlocked);

  // R3
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr == SETUP_OFS) |=> $stable(cur_bits));

  // R4
  unlock_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !(bus_we && bus_addr == KEY_OFS)) |=> unlocked);

  // R7
  eff_swap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    effective_swap |-> (cur_bits[3] && MODE_FLAG));

  // R6
  rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:5] == '0);
endmodule

bind cfg_lockreg cfg_lockreg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
  .KEY_OFS(KEY_OFS), .SETUP_OFS(SETUP_OFS), .MODE_FLAG(MODE_FLAG)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_be         (bus_be),
  .bus_rdata      (bus_rdata),
  .effective_swap (effective_swap),
  .unlocked       (unlocked),
  .cur_bits       (cur)
);

// File: tb/test_cfg_lockreg.sv
`timescale 1ns/1ps
module test_cfg_lockreg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_swap = 1'b1, strap_dbg = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_rdata;
  logic        effective_swap, inc_en, dma_en, dbg_en;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model state
  bit m_unl, m_swap, m_inc, m_dma, m_dbg;

  always #5 clk = ~clk;

  cfg_lockreg i_cfg_lockreg (
    .clk(clk), .rst_n(rst_n), .strap_swap(strap_swap), .strap_dbg(strap_dbg),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .effective_swap(effective_swap),
    .inc_en(inc_en), .dma_en(dma_en), .dbg_en(dbg_en)
  );

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a == 4'h4) return {27'd0, 1'b1, m_swap, m_inc, m_dma, m_dbg};
    return 32'd0;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare mid-cycle, update model at posedge
  task automatic step(input string tag, input bit rst, input bit we, input logic [3:0] a,
                      input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    rst_n = ~rst; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    #1;
    if (!rst) begin
      cmp(tag, "rdata", bus_rdata, exp_rd(a));
      cmp(tag, "effective_swap", {31'd0, effective_swap}, {31'd0, m_swap});
      cmp(tag, "inc_en", {31'd0, inc_en}, {31'd0, m_inc});
      cmp(tag, "dma_en", {31'd0, dma_en}, {31'd0, m_dma});
      cmp(tag, "dbg_en", {31'd0, dbg_en}, {31'd0, m_dbg});
    end
    @(posedge clk);
    if (rst) begin
      m_unl = 0; m_swap = strap_swap; m_dbg = strap_dbg; m_inc = 0; m_dma = 0;
    end else if (we && a == 4'h0) begin
      m_unl = (be == 4'hF) && (d == 32'hF123F456);
    end else if (we && a == 4'h4 && m_unl && be[0]) begin
      m_swap = d[3]; m_inc = d[2]; m_dma = d[1]; m_dbg = d[0];
    end
  endtask

  initial begin
    // R1 first reset, swap strap high, debug strap low
    strap_swap = 1; strap_dbg = 0;
    repeat (3) step("R1", 1, 0, 4'h0, 0, 0);
    step("R1", 0, 0, 4'h4, 0, 0);           // R6 readback after reset
    // R3 locked write ignored
    step("R3", 0, 1, 4'h4, 32'h0000_0006, 4'hF);
    step("R3", 0, 0, 4'h4, 0, 0);
    // R5 wrong key keeps it locked
    step("R5", 0, 1, 4'h0, 32'hF123F457, 4'hF);
    step("R3", 0, 1, 4'h4, 32'h0000_0007, 4'hF);
    step("R6", 0, 0, 4'h4, 0, 0);
    // R2 unlock then write
    step("R2", 0, 1, 4'h0, 32'hF123F456, 4'hF);
    step("R9", 0, 1, 4'h4, 32'h0000_0006, 4'h1);
    step("R9", 0, 0, 4'h4, 0, 0);
    // R4 persistence over several writes
    step("R4", 0, 1, 4'h4, 32'h0000_0009, 4'hF);
    step("R7", 0, 0, 4'h4, 0, 0);
    step("R4", 0, 1, 4'h4, 32'h0000_0000, 4'hF);
    step("R4", 0, 1, 4'h4, 32'h0000_000F, 4'hF);
    step("R6", 0, 0, 4'h0, 0, 0);
    // R8 strobe 0 missing, and high bits incl. mode flag ignored
    step("R8", 0, 1, 4'h4, 32'h0000_0000, 4'hE);
    step("R8", 0, 0, 4'h4, 0, 0);
    step("R8", 0, 1, 4'h4, 32'hFFFF_FFE2, 4'hF);
    step("R8", 0, 0, 4'h4, 0, 0);
    // R10 unmapped address
    step("R10", 0, 1, 4'h8, 32'hFFFF_FFFF, 4'hF);
    step("R10", 0, 0, 4'h8, 0, 0);
    step("R10", 0, 0, 4'hC, 0, 0);
    // R5 key with partial strobe relocks
    step("R5", 0, 1, 4'h0, 32'hF123F456, 4'h7);
    step("R5", 0, 1, 4'h4, 32'h0000_000D, 4'hF);
    step("R5", 0, 0, 4'h4, 0, 0);
    // unlock again, write, relock with zero
    step("R2", 0, 1, 4'h0, 32'hF123F456, 4'hF);
    step("R2", 0, 1, 4'h4, 32'h0000_0005, 4'hF);
    step("R5", 0, 1, 4'h0, 32'h0000_0000, 4'hF);
    step("R5", 0, 1, 4'h4, 32'h0000_000A, 4'hF);
    step("R5", 0, 0, 4'h4, 0, 0);
    // R1 second reset with opposite straps
    strap_swap = 0; strap_dbg = 1;
    repeat (2) step("R1", 1, 0, 4'h0, 0, 0);
    step("R1", 0, 0, 4'h4, 0, 0);
    step("R3", 0, 1, 4'h4, 32'h0000_0008, 4'hF);
    step("R1", 0, 0, 4'h4, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule